// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Tag Controller

This block performs tag lookup and line management for an external, direct-mapped, write-back secondary cache. A processor presents one line request at a time: a byte address and a read/write flag. The controller looks the line up in an internal store of 8-bit tag entries, one per cache line, each with a separate valid flag. It then classifies the access as a hit, a miss that needs only a fill, or a miss that first needs the old line written back. Fill and write-back commands leave on a memory command port. The cache data array and memory timing are outside the block: only line-level commands are produced.

A static mode pin selects how each 8-bit entry is used. With the pin low, the entry holds eight address bits above the index, and any valid line that is replaced is written back. With the pin high, the top entry bit becomes a modified flag and only seven address bits are stored, which halves the cacheable range. In that mode only modified lines are written back. An address outside the cacheable range for the current mode bypasses the cache.

All three interfaces use valid/ready. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response has been taken. A memory command, once raised, holds its address and kind until `mem_cmd_ready` is seen. A response holds its flags until `rsp_ready` is seen. Changing `dirty_mode` requires a reset.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 while `mem_cmd_valid` and `rsp_valid` are 0. Every line is invalid, so the first access to any index is a miss that issues a single fill (`mem_cmd_write`=0) and no write-back.
- R2: A repeat access to a resident line returns `rsp_hit`=1 and `rsp_uncached`=0, and issues no memory command.
- R3: Address bits [OFF_W-1:0] select a byte and are ignored. The index is addr[OFF_W +: IDX_W], and the stored tag comes from addr[OFF_W+IDX_W +: 8]. Lines with different indexes never evict each other.
- R4: With `dirty_mode`=0, a miss on a valid line first issues a write-back (`mem_cmd_write`=1) at the old line's address, even if the line was never written. The fill (`mem_cmd_write`=0) of the new line follows.
- R5: With `dirty_mode`=1, a miss on a valid line that is not modified issues only the fill. A miss on a modified line issues the write-back and then the fill.
- R6: With `dirty_mode`=1, a write hit marks the line modified, and so does a fill caused by a write miss. A fill caused by a read miss leaves the line unmodified.
- R7: An address with any bit set above the cacheable range bypasses the cache. It issues exactly one command, at the line-aligned address and carrying the request's write flag, and returns `rsp_uncached`=1 and `rsp_hit`=0. It leaves the tag store unchanged.
- R8: The cacheable range is 2^(OFF_W+IDX_W+8) bytes with `dirty_mode`=0 and half that with `dirty_mode`=1. Address bit OFF_W+IDX_W+7 is therefore cacheable only in the first mode.
- R9: `req_ready` is low from acceptance until the response is taken. A pending memory command keeps its address and kind stable until accepted. A pending response keeps its flags until accepted.
- R10: A write hit issues no memory command in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dirty_mode | input | 1 | 1: seven tag bits plus modified flag; 0: eight tag bits |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Request hit a resident line |
| rsp_uncached | output | 1 | Request bypassed the cache |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_write | output | 1 | 1 = line write, 0 = line read |
| mem_cmd_addr | output | ADDR_W | Line-aligned memory address |

## Verification
The hardest situation to reach is a write-back triggered only by a line's modified flag. To get there, the same index must be filled, written without a memory command, and then evicted by a conflicting tag, all in the mode that keeps the flag. It must then be compared against a clean eviction and a write-miss fill at another index. The stimulus builds these sequences with directed requests after a reset into that mode. A table of conflicting, offset-varied and out-of-range addresses covers the plain mode. The memory and response sides stall each handshake for one cycle, so that the hold rules are exercised on every command.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL,
    ST_RESP
  } ctag_state_e;

  localparam int unsigned ENTRY_W = 8;
endpackage

// File: rtl/ctag_addr_split.sv
module ctag_addr_split #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        dirty_mode,
  output logic [IDX_W-1:0]            idx,
  output logic [ctag_pkg::ENTRY_W-1:0] tag,
  output logic                        cacheable
);
  localparam int unsigned TAG_LO = OFF_W + IDX_W;
  localparam int unsigned HI_LO  = TAG_LO + ctag_pkg::ENTRY_W;
  localparam int unsigned HI_W   = ADDR_W - HI_LO;

  logic hi_clear;

  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[TAG_LO +: ctag_pkg::ENTRY_W];

  generate
    if (HI_W > 0) begin : g_hi
      assign hi_clear = (addr[ADDR_W-1:HI_LO] == '0);
    end else begin : g_nohi
      assign hi_clear = 1'b1;
    end
  endgenerate

  assign cacheable = hi_clear && !(dirty_mode && tag[ctag_pkg::ENTRY_W-1]);
endmodule

// File: rtl/ctag_store.sv
module ctag_store #(
  parameter int unsigned IDX_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             idx,
  output logic [ctag_pkg::ENTRY_W-1:0] rd_entry,
  output logic                         rd_valid,
  input  logic                         wr_en,
  input  logic [ctag_pkg::ENTRY_W-1:0] wr_entry
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [ctag_pkg::ENTRY_W-1:0] entries [LINES];
  logic [LINES-1:0]             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) entries[idx] <= wr_entry;
  end

  assign rd_entry = entries[idx];
  assign rd_valid = valid_q[idx];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0));
endmodule

// File: rtl/ctag_fsm.sv
module ctag_fsm #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned IDX_W  = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dirty_mode,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         req_write,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic                         rsp_hit,
  output logic                         rsp_uncached,
  output logic                         mem_cmd_valid,
  input  logic                         mem_cmd_ready,
  output logic                         mem_cmd_write,
  output logic [ADDR_W-1:0]            mem_cmd_addr,
  output logic [ADDR_W-1:0]            lk_addr,
  input  logic [IDX_W-1:0]             lk_idx,
  input  logic [ctag_pkg::ENTRY_W-1:0] lk_tag,
  input  logic                         lk_cacheable,
  input  logic [ctag_pkg::ENTRY_W-1:0] st_entry,
  input  logic                         st_valid,
  output logic                         st_wr_en,
  output logic [ctag_pkg::ENTRY_W-1:0] st_wr_entry
);
  import ctag_pkg::*;

  localparam int unsigned TAG_LO = OFF_W + IDX_W;
  localparam int unsigned MSB    = ENTRY_W - 1;

  ctag_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, hit_q, unc_q;
  logic              tag_match, victim_dirty, need_wb;
  logic [ENTRY_W-1:0] victim_tag;
  logic [ADDR_W-1:0]  victim_addr;

  assign lk_addr = addr_q;

  always_comb begin
    if (dirty_mode) tag_match = (st_entry[MSB-1:0] == lk_tag[MSB-1:0]);
    else            tag_match = (st_entry == lk_tag);
  end

  assign victim_dirty = dirty_mode ? st_entry[MSB] : 1'b1;
  assign need_wb      = st_valid && victim_dirty;
  assign victim_tag   = dirty_mode ? {1'b0, st_entry[MSB-1:0]} : st_entry;

  always_comb begin
    victim_addr = '0;
    victim_addr[OFF_W +: IDX_W]    = lk_idx;
    victim_addr[TAG_LO +: ENTRY_W] = victim_tag;
  end

  always_comb begin
    state_d     = state_q;
    st_wr_en    = 1'b0;
    st_wr_entry = lk_tag;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (!lk_cacheable) begin
          state_d = ST_FILL;
        end else if (st_valid && tag_match) begin
          state_d = ST_RESP;
          if (dirty_mode && wr_q) begin
            st_wr_en    = 1'b1;
            st_wr_entry = {1'b1, st_entry[MSB-1:0]};
          end
        end else if (need_wb) begin
          state_d = ST_WB;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WB:     if (mem_cmd_ready) state_d = ST_FILL;
      ST_FILL: begin
        if (mem_cmd_ready) begin
          state_d = ST_RESP;
          if (!unc_q) begin
            st_wr_en    = 1'b1;
            st_wr_entry = dirty_mode ? {wr_q, lk_tag[MSB-1:0]} : lk_tag;
          end
        end
      end
      ST_RESP:   if (rsp_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      hit_q   <= 1'b0;
      unc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        addr_q <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        wr_q   <= req_write;
        hit_q  <= 1'b0;
        unc_q  <= 1'b0;
      end
      if (state_q == ST_LOOKUP) begin
        unc_q <= !lk_cacheable;
        hit_q <= lk_cacheable && st_valid && tag_match;
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_hit       = hit_q;
  assign rsp_uncached  = unc_q;
  assign mem_cmd_valid = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_cmd_write = (state_q == ST_WB) || (unc_q && wr_q);
  assign mem_cmd_addr  = (state_q == ST_WB) ? victim_addr : addr_q;

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write)));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_hit) && $stable(rsp_uncached)));

  // R9
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_cmd_valid, rsp_valid}));

  // R4
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB && mem_cmd_ready) |=> (mem_cmd_valid && !mem_cmd_write));

  // R7
  bypass_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |-> !(state_q == ST_FILL && unc_q));
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dirty_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_uncached,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [ADDR_W-1:0] mem_cmd_addr
);
  localparam int unsigned EW = ctag_pkg::ENTRY_W;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [EW-1:0]     lk_tag, st_entry, st_wr_entry;
  logic              lk_cacheable, st_valid, st_wr_en;

  ctag_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .addr(lk_addr), .dirty_mode(dirty_mode),
    .idx(lk_idx), .tag(lk_tag), .cacheable(lk_cacheable)
  );

  ctag_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(lk_idx),
    .rd_entry(st_entry), .rd_valid(st_valid),
    .wr_en(st_wr_en), .wr_entry(st_wr_entry)
  );

  ctag_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dirty_mode(dirty_mode),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_uncached(rsp_uncached),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
    .lk_addr(lk_addr), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .lk_cacheable(lk_cacheable), .st_entry(st_entry), .st_valid(st_valid),
    .st_wr_en(st_wr_en), .st_wr_entry(st_wr_entry)
  );
endmodule

// File: tb/cache_tag_ctrl_test.sv
`timescale 1ns/1ps
module cache_tag_ctrl_test;
  localparam int unsigned AW = 20;
  localparam int unsigned OW = 5;
  localparam int unsigned IW = 4;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          wr;
    logic [1:0]    n;
    logic          c0w;
    logic [AW-1:0] c0a;
    logic          c1w;
    logic [AW-1:0] c1a;
    logic          hit;
    logic          unc;
  } vec_t;

  function automatic logic [AW-1:0] mk(input int tg, input int ix, input int of);
    return AW'((tg << (OW + IW)) | (ix << OW) | of);
  endfunction

  localparam logic [AW-1:0] BYP = AW'(1 << 17);

  localparam vec_t TBL [0:9] = '{
    '{mk(1,2,3),   1'b0, 2'd1, 1'b0, mk(1,2,0),       1'b0, '0,          1'b0, 1'b0},
    '{mk(1,2,31),  1'b0, 2'd0, 1'b0, '0,              1'b0, '0,          1'b1, 1'b0},
    '{mk(1,2,0),   1'b1, 2'd0, 1'b0, '0,              1'b0, '0,          1'b1, 1'b0},
    '{mk(2,2,0),   1'b0, 2'd2, 1'b1, mk(1,2,0),       1'b0, mk(2,2,0),   1'b0, 1'b0},
    '{mk(2,3,0),   1'b0, 2'd1, 1'b0, mk(2,3,0),       1'b0, '0,          1'b0, 1'b0},
    '{mk(2,2,4),   1'b0, 2'd0, 1'b0, '0,              1'b0, '0,          1'b1, 1'b0},
    '{BYP|mk(5,2,9), 1'b1, 2'd1, 1'b1, BYP|mk(5,2,0), 1'b0, '0,          1'b0, 1'b1},
    '{mk(2,2,0),   1'b0, 2'd0, 1'b0, '0,              1'b0, '0,          1'b1, 1'b0},
    '{mk(128,2,0), 1'b0, 2'd2, 1'b1, mk(2,2,0),       1'b0, mk(128,2,0), 1'b0, 1'b0},
    '{mk(128,2,8), 1'b0, 2'd0, 1'b0, '0,              1'b0, '0,          1'b1, 1'b0}
  };
  string vec_req [0:9] = '{"R1", "R3", "R10", "R4", "R3", "R2", "R7", "R7", "R8", "R2"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dirty_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic rsp_valid, rsp_hit, rsp_uncached;
  logic rsp_ready = 1'b0;
  logic mem_cmd_valid, mem_cmd_write;
  logic mem_cmd_ready = 1'b0;
  logic [AW-1:0] mem_cmd_addr;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cache_tag_ctrl #(.ADDR_W(AW), .OFF_W(OW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .dirty_mode(dirty_mode),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_uncached(rsp_uncached),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    dirty_mode = mode;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(mem_cmd_valid == 1'b0, "R1", "mem_cmd_valid after reset", mem_cmd_valid, 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic run_req(input vec_t v, input string rq);
    logic [AW-1:0] ca [2];
    logic          cw [2];
    int            ncmd = 0;
    bit            cstall = 0, rstall = 0, done = 0, hold_ok = 1, busy_ok = 1;
    logic [AW-1:0] sa = '0;
    logic          sw = 1'b0;
    logic          gh = 1'b0, gu = 1'b0;
    ca[0] = '0; ca[1] = '0; cw[0] = 1'b0; cw[1] = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = v.addr;
    req_write = v.wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      if (mem_cmd_ready) mem_cmd_ready = 1'b0;
      if (rsp_ready) begin
        rsp_ready = 1'b0;
        done = 1;
      end else begin
        if (req_ready) busy_ok = 0;
        if (mem_cmd_valid) begin
          if (!cstall) begin
            cstall = 1; sa = mem_cmd_addr; sw = mem_cmd_write;
          end else begin
            if (mem_cmd_addr != sa || mem_cmd_write != sw) hold_ok = 0;
            if (ncmd < 2) begin
              ca[ncmd] = mem_cmd_addr; cw[ncmd] = mem_cmd_write;
            end
            ncmd++;
            cstall = 0;
            mem_cmd_ready = 1'b1;
          end
        end else if (rsp_valid) begin
          if (!rstall) begin
            rstall = 1; gh = rsp_hit; gu = rsp_uncached;
          end else begin
            if (rsp_hit != gh || rsp_uncached != gu) hold_ok = 0;
            rsp_ready = 1'b1;
          end
        end
      end
      if (!done) @(negedge clk);
    end
    chk(done, rq, "response returned", done, 1);
    chk(busy_ok && hold_ok, "R9", "handshake hold rules", {busy_ok, hold_ok}, 2'b11);
    chk(ncmd == int'(v.n), rq, "memory command count", ncmd, v.n);
    if (v.n > 0 && ncmd > 0) begin
      chk(cw[0] == v.c0w, rq, "first command kind", cw[0], v.c0w);
      chk(ca[0] == v.c0a, rq, "first command address", ca[0], v.c0a);
    end
    if (v.n > 1 && ncmd > 1) begin
      chk(cw[1] == v.c1w, rq, "second command kind", cw[1], v.c1w);
      chk(ca[1] == v.c1a, rq, "second command address", ca[1], v.c1a);
    end
    chk(gh == v.hit, rq, "rsp_hit", gh, v.hit);
    chk(gu == v.unc, rq, "rsp_uncached", gu, v.unc);
    chk(req_ready == 1'b1, "R9", "req_ready back after response", req_ready, 1);
  endtask

  function automatic vec_t dv(input logic [AW-1:0] a, input logic w, input int n,
                              input logic w0, input logic [AW-1:0] a0,
                              input logic [AW-1:0] a1, input logic h, input logic u);
    vec_t r;
    r.addr = a; r.wr = w; r.n = 2'(n); r.c0w = w0; r.c0a = a0;
    r.c1w = 1'b0; r.c1a = a1; r.hit = h; r.unc = u;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) run_req(TBL[i], vec_req[i]);

    do_reset(1'b1);
    // R1 first access after reset in flag mode
    run_req(dv(mk(1,4,0), 1'b0, 1, 1'b0, mk(1,4,0), '0, 1'b0, 1'b0), "R1");
    // R5 clean victim: fill only
    run_req(dv(mk(9,4,0), 1'b0, 1, 1'b0, mk(9,4,0), '0, 1'b0, 1'b0), "R5");
    // R10 write hit: no command, R6 marks modified
    run_req(dv(mk(9,4,5), 1'b1, 0, 1'b0, '0, '0, 1'b1, 1'b0), "R10");
    // R6 modified victim written back, then fill
    run_req(dv(mk(3,4,0), 1'b0, 2, 1'b1, mk(9,4,0), mk(3,4,0), 1'b0, 1'b0), "R6");
    // R6 write miss fill marks modified
    run_req(dv(mk(7,5,0), 1'b1, 1, 1'b0, mk(7,5,0), '0, 1'b0, 1'b0), "R6");
    run_req(dv(mk(1,5,0), 1'b0, 2, 1'b1, mk(7,5,0), mk(1,5,0), 1'b0, 1'b0), "R6");
    // R8 bit 16 is out of range in flag mode
    run_req(dv(mk(128,5,2), 1'b0, 1, 1'b0, mk(128,5,0), '0, 1'b0, 1'b1), "R8");
    // R7 bypass left the line at index 5 untouched
    run_req(dv(mk(1,5,0), 1'b0, 0, 1'b0, '0, '0, 1'b1, 1'b0), "R7");
    // R5 read-filled line is clean: fill only
    run_req(dv(mk(2,5,0), 1'b0, 1, 1'b0, mk(2,5,0), '0, 1'b0, 1'b0), "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule